// File: doc/BRIEF.md
# Receive Channel-Identifier Lookup

This block turns the channel identifier of an arriving frame into the context entry that owns the frame and the address of the receive descriptor the frame should use. An identifier arrives with a strobe, together with the byte base addresses of the lookup table and the context table and a table-size select. The block then walks two tables in shared memory through a single 16-bit read port. First it reads one lookup word. Then, if that word marks the channel active, it reads the control word and the ring fields of a context entry.

The result leaves on a valid/ready handshake. It is either an accept, carrying the context index and the descriptor address, or a discard. Several identifiers can steer their frames into one common descriptor ring, and each of them still reports its own context index. The frame-writing logic can therefore keep per-channel counters separate. The block handles one identifier at a time.

Top module: `rx_chanid_resolve`

## Requirements
- R1: After reset, `id_ready` is 1, `res_valid` is 0 and `mem_req` is 0.
- R2: The first read of a lookup is at `lut_base + 2*id`, so identifier 0 reads the word at `lut_base` itself.
- R3: With `big_table` = 0 the table holds identifiers 0..1023. A larger identifier is discarded without any memory read. With `big_table` = 1, every identifier 0..8191 is looked up.
- R4: Bit 15 of the lookup word is the active flag and bits 12:0 are the context index. If the active flag is 0, the frame is discarded after that single read and the context table is never read.
- R5: A context entry is 32 bytes long, starting at `ctx_base + 32*index`. Its control word sits at byte offset 16, and bit 15 of that word is receive-ready. If receive-ready is 0, the frame is discarded after the second read.
- R6: On accept, `res_desc_addr` = ring base + 8*current index. The ring base takes its low 16 bits from the word at entry offset 18 and its high 8 bits from bits 7:0 of the word at offset 20. The current index is bits 11:0 of the word at offset 22. `res_ctx_idx` is the index from the lookup word.
- R7: When bit 14 of the control word is set, the three ring words are read from the entry whose index is in control bits 12:0, not from the frame's own entry. `res_ctx_idx` still reports the frame's own index.
- R8: `id_ready` is 0 from the cycle after an identifier is taken until its result has been consumed. Strobes during that time are ignored and produce no result.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_accept`, `res_ctx_idx` and `res_desc_addr` hold their values.
- R10: `mem_req` is a one-cycle pulse. No new request is issued until `mem_rvalid` has returned the previous word.
- R11: A lookup issues exactly 0, 1, 2 or 5 reads for an out-of-range, inactive, not-ready or accepted frame respectively. On discard (`res_accept` = 0), the index and address outputs carry no meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Identifier strobe |
| id_ready | output | 1 | Block can take an identifier |
| id_value | input | 13 | Channel identifier of the frame |
| big_table | input | 1 | 0: 1024-entry lookup table, 1: 8192-entry table |
| lut_base | input | 24 | Byte address of lookup word for identifier 0 |
| ctx_base | input | 24 | Byte address of context entry 0 |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 24 | Byte address of the 16-bit word to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_accept | output | 1 | 1: frame accepted, 0: discarded |
| res_ctx_idx | output | 13 | Context index of the frame |
| res_desc_addr | output | 24 | Byte address of the receive descriptor |

## Verification
The hardest case to reach is a shared ring. The lookup word, the frame's own control word and a second entry's ring words all have to line up before the redirect matters. The bench fills the frame's own entry with ring words that differ from the owner's, so a wrong redirect shows up as a wrong address. Busy-time strobes are made by holding the strobe high for one cycle after the identifier has been taken, with a different identifier. Read latency varies from one to three cycles, and consumer backpressure comes from a shift-register pattern, so results are held over several cycles.

// File: rtl/rxl_pkg.sv
// Package: shared state encoding and table layout constants for the
// receive channel-identifier lookup. Assumes 16-bit memory words.
package rxl_pkg;

    // Sequencer states: each read has a request state and a wait state.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LUT_REQ,
        ST_LUT_WAIT,
        ST_CTL_REQ,
        ST_CTL_WAIT,
        ST_RLO_REQ,
        ST_RLO_WAIT,
        ST_RHI_REQ,
        ST_RHI_WAIT,
        ST_CUR_REQ,
        ST_CUR_WAIT
    } seq_state_t;

    // Word offsets inside one 16-word context entry.
    localparam logic [3:0] CTL_WORD = 4'd8;
    localparam logic [3:0] RLO_WORD = 4'd9;
    localparam logic [3:0] RHI_WORD = 4'd10;
    localparam logic [3:0] CUR_WORD = 4'd11;

    // log2 of the context entry size in bytes (16 words).
    localparam int unsigned ENTRY_LG = 5;

    // Bit positions in the lookup word and control word.
    localparam int unsigned ACT_BIT = 15;
    localparam int unsigned RDY_BIT = 15;
    localparam int unsigned SHR_BIT = 14;

endpackage

// File: rtl/rxl_addr_gen.sv
// Module: rxl_addr_gen
// Forms the byte address of the next read. It is either a lookup word
// (base + 2*id) or a word inside a context entry
// (base + 32*index + 2*word). It is purely combinational.
// Assumes that AW is wide enough that no address wraps.
module rxl_addr_gen
    import rxl_pkg::*;
#(
    parameter int unsigned AW    = 24,
    parameter int unsigned ID_W  = 13,
    parameter int unsigned IDX_W = 13
) (
    input  logic             lut_phase,
    input  logic [AW-1:0]    lut_base,
    input  logic [AW-1:0]    ctx_base,
    input  logic [ID_W-1:0]  id,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       word,
    output logic [AW-1:0]    addr
);

    logic [AW-1:0] lut_addr;
    logic [AW-1:0] ctx_addr;

    // Lookup word address: one 16-bit word per identifier.
    assign lut_addr = lut_base + (AW'(id) << 1);

    // Context word address: entry offset plus word offset.
    assign ctx_addr = ctx_base + (AW'(idx) << ENTRY_LG) + (AW'(word) << 1);

    // Select which table the current read targets.
    assign addr = lut_phase ? lut_addr : ctx_addr;

endmodule

// File: rtl/rxl_seq.sv
// Module: rxl_seq
// Sequencer for one lookup. It checks the identifier range, reads the
// lookup word, then the control word and three ring words of the ring
// owner. At the end it issues one load to the result register, either
// an accept or a discard. Assumes one outstanding read, answered by
// mem_rvalid at least one cycle after the request, and AW > 16.
module rxl_seq
    import rxl_pkg::*;
#(
    parameter int unsigned AW       = 24,
    parameter int unsigned ID_W     = 13,
    parameter int unsigned IDX_W    = 13,
    parameter int unsigned SMALL_LG = 10,
    parameter int unsigned CUR_W    = 12,
    parameter int unsigned DESC_LG  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ID_W-1:0]  id_in,
    input  logic             big_table,
    input  logic             mem_rvalid,
    input  logic [15:0]      mem_rdata,
    output logic             idle,
    output logic             mem_req,
    output logic             lut_phase,
    output logic [IDX_W-1:0] addr_idx,
    output logic [3:0]       addr_word,
    output logic [ID_W-1:0]  id_q,
    output logic             load,
    output logic             load_accept,
    output logic [IDX_W-1:0] load_idx,
    output logic [AW-1:0]    load_addr
);

    localparam int unsigned HI_W = AW - 16;

    seq_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  owner_q;
    logic [15:0]       rlo_q;
    logic [HI_W-1:0]   rhi_q;
    logic              out_of_range;

    // Identifier lies beyond the small table when that size is selected.
    assign out_of_range = !big_table && ((id_in >> SMALL_LG) != '0);

    // Next-state and result-load decode.
    always_comb begin
        state_d     = state_q;
        load        = 1'b0;
        load_accept = 1'b0;
        load_addr   = '0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (out_of_range) begin
                        load = 1'b1;
                    end else begin
                        state_d = ST_LUT_REQ;
                    end
                end
            end
            ST_LUT_REQ:  state_d = ST_LUT_WAIT;
            ST_LUT_WAIT: begin
                if (mem_rvalid) begin
                    if (mem_rdata[ACT_BIT]) begin
                        state_d = ST_CTL_REQ;
                    end else begin
                        load    = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_CTL_REQ:  state_d = ST_CTL_WAIT;
            ST_CTL_WAIT: begin
                if (mem_rvalid) begin
                    if (mem_rdata[RDY_BIT]) begin
                        state_d = ST_RLO_REQ;
                    end else begin
                        load    = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_RLO_REQ:  state_d = ST_RLO_WAIT;
            ST_RLO_WAIT: if (mem_rvalid) state_d = ST_RHI_REQ;
            ST_RHI_REQ:  state_d = ST_RHI_WAIT;
            ST_RHI_WAIT: if (mem_rvalid) state_d = ST_CUR_REQ;
            ST_CUR_REQ:  state_d = ST_CUR_WAIT;
            ST_CUR_WAIT: begin
                if (mem_rvalid) begin
                    load        = 1'b1;
                    load_accept = 1'b1;
                    load_addr   = {rhi_q, rlo_q}
                                + (AW'(mem_rdata[CUR_W-1:0]) << DESC_LG);
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the identifier and the fields read back from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            idx_q   <= '0;
            owner_q <= '0;
            rlo_q   <= '0;
            rhi_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                id_q <= id_in;
            end
            if (state_q == ST_LUT_WAIT && mem_rvalid) begin
                idx_q   <= mem_rdata[IDX_W-1:0];
                owner_q <= mem_rdata[IDX_W-1:0];
            end
            if (state_q == ST_CTL_WAIT && mem_rvalid && mem_rdata[SHR_BIT]) begin
                owner_q <= mem_rdata[IDX_W-1:0];
            end
            if (state_q == ST_RLO_WAIT && mem_rvalid) begin
                rlo_q <= mem_rdata;
            end
            if (state_q == ST_RHI_WAIT && mem_rvalid) begin
                rhi_q <= mem_rdata[HI_W-1:0];
            end
        end
    end

    // Request pulse and address selection for the current state.
    always_comb begin
        mem_req   = 1'b0;
        addr_word = 4'd0;
        case (state_q)
            ST_LUT_REQ: mem_req = 1'b1;
            ST_CTL_REQ: begin mem_req = 1'b1; addr_word = CTL_WORD; end
            ST_RLO_REQ: begin mem_req = 1'b1; addr_word = RLO_WORD; end
            ST_RHI_REQ: begin mem_req = 1'b1; addr_word = RHI_WORD; end
            ST_CUR_REQ: begin mem_req = 1'b1; addr_word = CUR_WORD; end
            default:    mem_req = 1'b0;
        endcase
    end

    assign lut_phase = (state_q == ST_LUT_REQ);
    assign addr_idx  = (state_q == ST_CTL_REQ) ? idx_q : owner_q;
    assign idle      = (state_q == ST_IDLE);
    assign load_idx  = idx_q;

endmodule

// File: rtl/rxl_result.sv
// Module: rxl_result
// Holding register for the lookup result. It is loaded once per lookup
// and emptied by the valid/ready handshake. Assumes that a load never
// arrives while a result is still held.
module rxl_result #(
    parameter int unsigned AW    = 24,
    parameter int unsigned IDX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_accept,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [AW-1:0]    load_addr,
    input  logic             res_ready,
    output logic             res_valid,
    output logic             res_accept,
    output logic [IDX_W-1:0] res_ctx_idx,
    output logic [AW-1:0]    res_desc_addr
);

    // Valid flag: set on load, cleared when the consumer takes the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
        end else if (load) begin
            res_valid <= 1'b1;
        end else if (res_valid && res_ready) begin
            res_valid <= 1'b0;
        end
    end

    // Payload: written only on load, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_accept    <= 1'b0;
            res_ctx_idx   <= '0;
            res_desc_addr <= '0;
        end else if (load) begin
            res_accept    <= load_accept;
            res_ctx_idx   <= load_idx;
            res_desc_addr <= load_addr;
        end
    end

endmodule

// File: rtl/rx_chanid_resolve.sv
// Module: rx_chanid_resolve
// Top of the receive channel-identifier lookup. It takes one identifier
// at a time, resolves it through the lookup table and the context table
// in shared memory, and presents an accept or discard result.
// Assumes that the bases and big_table stay stable during a lookup.
module rx_chanid_resolve #(
    parameter int unsigned AW       = 24,
    parameter int unsigned ID_W     = 13,
    parameter int unsigned IDX_W    = 13,
    parameter int unsigned SMALL_LG = 10,
    parameter int unsigned CUR_W    = 12,
    parameter int unsigned DESC_LG  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    output logic             id_ready,
    input  logic [ID_W-1:0]  id_value,
    input  logic             big_table,
    input  logic [AW-1:0]    lut_base,
    input  logic [AW-1:0]    ctx_base,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [15:0]      mem_rdata,
    output logic             res_valid,
    input  logic             res_ready,
    output logic             res_accept,
    output logic [IDX_W-1:0] res_ctx_idx,
    output logic [AW-1:0]    res_desc_addr
);

    logic             seq_idle;
    logic             start;
    logic             lut_phase;
    logic [IDX_W-1:0] addr_idx;
    logic [3:0]       addr_word;
    logic [ID_W-1:0]  id_q;
    logic             load;
    logic             load_accept;
    logic [IDX_W-1:0] load_idx;
    logic [AW-1:0]    load_addr;

    // Take a new identifier only when idle and the result slot is empty.
    assign id_ready = seq_idle && !res_valid;
    assign start    = id_valid && id_ready;

    rxl_seq #(
        .AW(AW), .ID_W(ID_W), .IDX_W(IDX_W),
        .SMALL_LG(SMALL_LG), .CUR_W(CUR_W), .DESC_LG(DESC_LG)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .id_in       (id_value),
        .big_table   (big_table),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .idle        (seq_idle),
        .mem_req     (mem_req),
        .lut_phase   (lut_phase),
        .addr_idx    (addr_idx),
        .addr_word   (addr_word),
        .id_q        (id_q),
        .load        (load),
        .load_accept (load_accept),
        .load_idx    (load_idx),
        .load_addr   (load_addr)
    );

    rxl_addr_gen #(
        .AW(AW), .ID_W(ID_W), .IDX_W(IDX_W)
    ) u_addr (
        .lut_phase (lut_phase),
        .lut_base  (lut_base),
        .ctx_base  (ctx_base),
        .id        (id_q),
        .idx       (addr_idx),
        .word      (addr_word),
        .addr      (mem_addr)
    );

    rxl_result #(
        .AW(AW), .IDX_W(IDX_W)
    ) u_res (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .load_accept   (load_accept),
        .load_idx      (load_idx),
        .load_addr     (load_addr),
        .res_ready     (res_ready),
        .res_valid     (res_valid),
        .res_accept    (res_accept),
        .res_ctx_idx   (res_ctx_idx),
        .res_desc_addr (res_desc_addr)
    );

endmodule

// File: rtl/rxl_chk.sv
// Module: rxl_chk
// Protocol and ordering checker for rx_chanid_resolve, attached by bind.
// It tracks each lookup from the moment the identifier is taken until
// the result is consumed.
module rxl_chk #(
    parameter int unsigned AW       = 24,
    parameter int unsigned ID_W     = 13,
    parameter int unsigned IDX_W    = 13,
    parameter int unsigned SMALL_LG = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_valid,
    input logic             id_ready,
    input logic [ID_W-1:0]  id_value,
    input logic             big_table,
    input logic [AW-1:0]    lut_base,
    input logic             mem_req,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_rvalid,
    input logic [15:0]      mem_rdata,
    input logic             res_valid,
    input logic             res_ready,
    input logic             res_accept,
    input logic [IDX_W-1:0] res_ctx_idx,
    input logic [AW-1:0]    res_desc_addr
);

    logic            outst;
    logic            busy;
    logic            first_req;
    logic            lut_pend;
    logic            oor;
    logic            inact;
    logic [ID_W-1:0] cap_id;
    logic [AW-1:0]   cap_base;
    logic            taken;
    logic            took;

    assign taken = res_valid && res_ready;
    assign took  = id_valid && id_ready;

    // Track the outstanding read and the phase of the current lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst     <= 1'b0;
            busy      <= 1'b0;
            first_req <= 1'b0;
            lut_pend  <= 1'b0;
            oor       <= 1'b0;
            inact     <= 1'b0;
            cap_id    <= '0;
            cap_base  <= '0;
        end else begin
            if (mem_req) outst <= 1'b1;
            else if (mem_rvalid) outst <= 1'b0;
            if (took) begin
                busy      <= 1'b1;
                first_req <= 1'b1;
                cap_id    <= id_value;
                cap_base  <= lut_base;
                oor       <= !big_table && ((id_value >> SMALL_LG) != '0);
            end else if (taken) begin
                busy  <= 1'b0;
                oor   <= 1'b0;
                inact <= 1'b0;
            end
            if (mem_req && first_req) begin
                first_req <= 1'b0;
                lut_pend  <= 1'b1;
            end
            if (mem_rvalid && lut_pend) begin
                lut_pend <= 1'b0;
                inact    <= !mem_rdata[15];
            end
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (id_ready && !res_valid && !mem_req));

    a_r2_lut_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (first_req && mem_req) |-> (mem_addr == cap_base + (AW'(cap_id) << 1)));

    a_r3_oor_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        oor |-> !mem_req);

    a_r3_oor_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (oor && res_valid) |-> !res_accept);

    a_r4_inactive_stop: assert property (@(posedge clk) disable iff (!rst_n)
        inact |-> !mem_req);

    a_r4_inactive_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (inact && res_valid) |-> !res_accept);

    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !id_ready);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_accept)
            && $stable(res_ctx_idx) && $stable(res_desc_addr)));

    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !outst);

endmodule

bind rx_chanid_resolve rxl_chk #(
    .AW(AW), .ID_W(ID_W), .IDX_W(IDX_W), .SMALL_LG(SMALL_LG)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .id_valid      (id_valid),
    .id_ready      (id_ready),
    .id_value      (id_value),
    .big_table     (big_table),
    .lut_base      (lut_base),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_accept    (res_accept),
    .res_ctx_idx   (res_ctx_idx),
    .res_desc_addr (res_desc_addr)
);

// File: tb/rx_chanid_resolve_tb_top.sv
// Scoreboard bench for rx_chanid_resolve. The driver computes the
// expected result from its own memory image and pushes it. The monitor
// pops and compares it when the design hands a result over.
module rx_chanid_resolve_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 1'b0;
    logic        id_ready;
    logic [12:0] id_value = '0;
    logic        big_table = 1'b0;
    logic [23:0] lut_base = '0;
    logic [23:0] ctx_base = '0;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic        res_accept;
    logic [12:0] res_ctx_idx;
    logic [23:0] res_desc_addr;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          acc;
        logic [12:0] idx;
        logic [23:0] addr;
        int          reads_end;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    logic [15:0] mem_w [int unsigned];
    int total_reads = 0;

    always #2 clk = ~clk;

    rx_chanid_resolve dut_i (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_ready(id_ready),
        .id_value(id_value), .big_table(big_table), .lut_base(lut_base),
        .ctx_base(ctx_base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .res_valid(res_valid),
        .res_ready(res_ready), .res_accept(res_accept), .res_ctx_idx(res_ctx_idx),
        .res_desc_addr(res_desc_addr)
    );

    function automatic logic [15:0] rd(input logic [23:0] a);
        if (mem_w.exists(int'(a))) return mem_w[int'(a)];
        return 16'h0000;
    endfunction

    task automatic wr(input logic [23:0] a, input logic [15:0] v);
        mem_w[int'(a)] = v;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected result built from the requirements and the memory image.
    function automatic exp_t model(input logic [12:0] id, input bit big,
                                   input logic [23:0] lb, input logic [23:0] cb,
                                   input int r0, input string tag);
        exp_t e;
        logic [15:0] w, c, lo, hi, cur;
        logic [12:0] own;
        e.tag = tag; e.acc = 0; e.idx = '0; e.addr = '0;
        if (!big && id >= 13'd1024) begin e.reads_end = r0; return e; end
        w = rd(lb + 24'(id) * 2);
        if (!w[15]) begin e.reads_end = r0 + 1; return e; end
        e.idx = w[12:0];
        c = rd(cb + 24'(e.idx) * 32 + 16);
        if (!c[15]) begin e.reads_end = r0 + 2; return e; end
        own = c[14] ? c[12:0] : e.idx;
        lo  = rd(cb + 24'(own) * 32 + 18);
        hi  = rd(cb + 24'(own) * 32 + 20);
        cur = rd(cb + 24'(own) * 32 + 22);
        e.acc = 1;
        e.addr = {hi[7:0], lo} + 24'(cur[11:0]) * 8;
        e.reads_end = r0 + 5;
        return e;
    endfunction

    // Memory model: one outstanding read, latency cycling through 1..3.
    bit          pend = 0;
    int          cnt = 0;
    int          lat = 0;
    logic [23:0] paddr = '0;
    always @(negedge clk) begin
        if (mem_rvalid) mem_rvalid = 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd(paddr);
                pend = 0;
            end else begin
                cnt--;
            end
        end
        if (rst_n && mem_req) begin
            if (pend || mem_rvalid)
                check(0, "R10", "request while read outstanding", 1, 0);
            pend  = 1;
            paddr = mem_addr;
            cnt   = lat;
            lat   = (lat + 1) % 3;
            total_reads++;
        end
    end

    // Monitor: backpressure pattern, hold check, scoreboard compare.
    logic [7:0]  lfsr = 8'hA5;
    bit          held = 0;
    logic        h_acc;
    logic [12:0] h_idx;
    logic [23:0] h_addr;
    always @(negedge clk) begin
        bit r_new;
        exp_t e;
        lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        r_new = lfsr[0] | lfsr[1];
        if (rst_n) begin
            if (held) begin
                check(res_valid === 1'b1, "R9", "valid dropped while stalled", res_valid, 1);
                check(res_accept === h_acc && res_ctx_idx === h_idx && res_desc_addr === h_addr,
                      "R9", "result changed while stalled", res_desc_addr, h_addr);
            end
            if (res_valid && r_new) begin
                if (sb_q.size() == 0) begin
                    check(0, "R8", "unexpected result", res_ctx_idx, 0);
                end else begin
                    e = sb_q.pop_front();
                    check(res_accept === e.acc, e.tag, "accept", res_accept, e.acc);
                    if (e.acc) begin
                        check(res_ctx_idx === e.idx, e.tag, "ctx index", res_ctx_idx, e.idx);
                        check(res_desc_addr === e.addr, e.tag, "desc addr", res_desc_addr, e.addr);
                    end
                    check(total_reads == e.reads_end, "R11", {"read count ", e.tag},
                          total_reads, e.reads_end);
                end
            end
            held = res_valid && !r_new;
            h_acc = res_accept; h_idx = res_ctx_idx; h_addr = res_desc_addr;
        end
        res_ready = r_new;
    end

    // Driver: wait for idle, push expectation, strobe the identifier.
    task automatic lookup(input logic [12:0] id, input bit big, input logic [23:0] lb,
                          input logic [23:0] cb, input string tag, input bit stray);
        do @(negedge clk); while (!id_ready);
        #1;
        sb_q.push_back(model(id, big, lb, cb, total_reads, tag));
        big_table = big; lut_base = lb; ctx_base = cb;
        id_value = id; id_valid = 1'b1;
        @(negedge clk);
        #1;
        if (stray) begin
            // R8: strobe with another identifier while busy; must be ignored.
            check(id_ready === 1'b0, "R8", "ready while busy", id_ready, 0);
            id_value = id ^ 13'h0155;
            @(negedge clk);
            #1;
        end
        id_valid = 1'b0;
    endtask

    task automatic ctx_entry(input logic [23:0] cb, input int idx, input logic [15:0] ctl,
                             input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] cur);
        wr(cb + 24'(idx) * 32 + 16, ctl);
        wr(cb + 24'(idx) * 32 + 18, lo);
        wr(cb + 24'(idx) * 32 + 20, hi);
        wr(cb + 24'(idx) * 32 + 22, cur);
    endtask

    localparam logic [23:0] LB1 = 24'h010000, CB1 = 24'h200000;
    localparam logic [23:0] LB2 = 24'h080000, CB2 = 24'h400000;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R8", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Small-table image.
        wr(LB1 + 0,    16'h8003);           // id 0 -> ctx 3
        wr(LB1 + 2046, 16'h8007);           // id 1023 -> ctx 7
        wr(LB1 + 100,  16'h0003);           // id 50 inactive
        wr(LB1 + 102,  16'h8009);           // id 51 -> ctx 9, not ready
        wr(LB1 + 80,   16'h8005);           // id 40 -> ctx 5 (shared)
        wr(LB1 + 82,   16'h8006);           // id 41 -> ctx 6 (owner)
        ctx_entry(CB1, 3, 16'h8000, 16'h1200, 16'h0034, 16'h0005);
        ctx_entry(CB1, 7, 16'h8000, 16'hFFF8, 16'h0012, 16'h0FFF);
        ctx_entry(CB1, 9, 16'h0000, 16'h7777, 16'h0077, 16'h0001);
        ctx_entry(CB1, 5, 16'hC006, 16'h1111, 16'h0011, 16'h0003);
        ctx_entry(CB1, 6, 16'h8000, 16'h4000, 16'h0056, 16'h0002);
        // Large-table image.
        wr(LB2 + 2048,  16'h9F40);          // id 1024 -> ctx 8000
        wr(LB2 + 16382, 16'h8001);          // id 8191 -> ctx 1
        ctx_entry(CB2, 8000, 16'h8000, 16'hABCD, 16'h00EF, 16'h0010);
        ctx_entry(CB2, 1,    16'h8000, 16'h0100, 16'h0000, 16'h0000);

        repeat (3) @(negedge clk);
        // R1: reset state.
        check(id_ready === 1'b1, "R1", "id_ready in reset", id_ready, 1);
        check(res_valid === 1'b0, "R1", "res_valid in reset", res_valid, 0);
        check(mem_req === 1'b0, "R1", "mem_req in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(id_ready === 1'b1 && res_valid === 1'b0, "R1", "idle after reset", id_ready, 1);

        lookup(13'd0,    0, LB1, CB1, "R2", 0);   // identifier 0 at the base
        lookup(13'd1023, 0, LB1, CB1, "R6", 0);   // carry into high address bits
        lookup(13'd1024, 0, LB1, CB1, "R3", 0);   // out of range in small mode
        lookup(13'd50,   0, LB1, CB1, "R4", 0);   // inactive
        lookup(13'd51,   0, LB1, CB1, "R5", 0);   // not receive-ready
        lookup(13'd40,   0, LB1, CB1, "R7", 0);   // redirected to ring of ctx 6
        lookup(13'd41,   0, LB1, CB1, "R7", 0);   // owner of the shared ring
        lookup(13'd1024, 1, LB2, CB2, "R3", 0);   // in range in big mode
        lookup(13'd8191, 1, LB2, CB2, "R3", 0);   // last identifier
        lookup(13'd0,    1, LB2, CB2, "R4", 0);   // empty word: inactive
        lookup(13'd0,    0, LB1, CB1, "R8", 1);   // stray strobe while busy
        lookup(13'd2000, 0, LB1, CB1, "R8", 1);   // stray during range discard

        for (int i = 0; i < 2000 && (sb_q.size() != 0 || res_valid); i++)
            @(negedge clk);
        repeat (20) @(negedge clk);
        check(sb_q.size() == 0, "R8", "results outstanding", sb_q.size(), 0);
        check(res_valid === 1'b0 && id_ready === 1'b1, "R8", "idle at end", res_valid, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule